// File: doc/BRIEF.md
# Address Security Attribute Resolver

This block tells the processor, for any address it presents, whether that address belongs to the secure world, is a non-secure-callable entry area, or is non-secure. It combines two independent sources of attribution. The first is a programmable set of address regions that secure software loads through a small write port. The second is a fixed map that splits every memory-map region into two aliases using a single address bit. The final answer is always the more secure of the two results.

The lookup path is purely combinational from the address to the attribute, so the result can feed a fetch or load/store check in the same cycle. The programming port is tagged with the security state of each access, and only secure accesses can change the configuration. After reset the programmable unit is off, and while it is off every address is secure. This keeps the processor in the secure world until software has set up the regions and switched the unit on.

Top module: `sau_attr_unit`

## Requirements
- R1: The attribute is reported as two flags, `attr_ns` and `attr_nsc`. Secure is 00, non-secure-callable is ns=0 nsc=1, and non-secure is ns=1 nsc=0. Both flags are never set together.
- R2: After a synchronous reset the unit is disabled and every region is cleared. Every address then resolves to secure with `region_hit`=0, `region_num`=0 and `multi_hit`=0.
- R3: A region matches when the region enable and the unit enable are both set and the address lies between base and limit inclusive. Base and limit are given as 32-byte granule numbers, and the limit covers its whole granule. A single match gives non-secure, or non-secure-callable if the region's callable bit is set. The match also sets `region_hit`=1 and drives the region index on `region_num`.
- R4: With the unit enabled, an address that matches no region is secure and `region_hit`=0.
- R5: If two or more regions match, the programmable result is secure, `multi_hit`=1, `region_hit`=0 and `region_num`=0.
- R6: The fixed source reports non-secure when address bit 28 is 0 and secure when it is 1.
- R7: The final attribute is the more secure of the fixed and programmable results, ranked secure > callable > non-secure. A fixed secure result forces secure. A fixed non-secure result passes the programmable result through.
- R8: Writes with `cfg_secure`=0 change no configuration state.
- R9: A secure write takes effect on the lookup from the clock edge that captures it, and not before. The write selector `cfg_kind` works as follows: 0 writes the unit enable from data bit 0; 1 writes the base granule; 2 writes the limit granule; 3 writes the region flags (bit 0 enable, bit 1 callable). The region is chosen by `cfg_region`.
- R10: A region whose enable bit is clear never matches. Clearing the unit enable returns every address to secure with no region reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_secure | input | 1 | Security state of the write access (1 = secure) |
| cfg_kind | input | 2 | Register selector: 0 enable, 1 base, 2 limit, 3 flags |
| cfg_region | input | 3 | Region index for base, limit and flag writes |
| cfg_wdata | input | 27 | Write data: granule number, or flags in low bits |
| lookup_addr | input | 32 | Address to attribute |
| attr_ns | output | 1 | Final non-secure flag |
| attr_nsc | output | 1 | Final non-secure-callable flag |
| region_hit | output | 1 | Exactly one programmable region matched |
| region_num | output | 3 | Index of the matching region |
| multi_hit | output | 1 | More than one region matched |

## Verification
The hardest situations to reach are the overlap case and the cases where the two sources disagree. The bench programs two regions that share part of a granule range, and places a callable region inside the secure alias. A single address sweep then reaches multi-hit, fixed-secure override and callable pass-through. The one-cycle write latency is checked by sampling the lookup once between the write being driven and its clock edge, and once after that edge.

// File: rtl/sau_pkg.sv
`timescale 1ns/1ps
package sau_pkg;

    localparam int SAU_ADDR_W    = 32;
    localparam int SAU_GRAN_LOG2 = 5;
    localparam int SAU_TAG_W     = SAU_ADDR_W - SAU_GRAN_LOG2;

    typedef struct packed {
        logic ns;
        logic nsc;
    } attr_t;

    localparam attr_t ATTR_SEC  = '{ns: 1'b0, nsc: 1'b0};
    localparam attr_t ATTR_NSC  = '{ns: 1'b0, nsc: 1'b1};
    localparam attr_t ATTR_NSEC = '{ns: 1'b1, nsc: 1'b0};

    typedef enum logic [1:0] {
        CFG_CTRL  = 2'd0,
        CFG_BASE  = 2'd1,
        CFG_LIMIT = 2'd2,
        CFG_FLAGS = 2'd3
    } cfg_kind_e;

    typedef struct packed {
        logic [SAU_TAG_W-1:0] base;
        logic [SAU_TAG_W-1:0] limit;
        logic                 en;
        logic                 nsc;
    } region_cfg_t;

    // 2 = secure, 1 = callable, 0 = non-secure
    function automatic logic [1:0] attr_rank(attr_t a);
        if (a.ns)       return 2'd0;
        else if (a.nsc) return 2'd1;
        else            return 2'd2;
    endfunction

    function automatic attr_t attr_stronger(attr_t a, attr_t b);
        return (attr_rank(a) >= attr_rank(b)) ? a : b;
    endfunction

endpackage

// File: rtl/sau_cfg_regs.sv
`timescale 1ns/1ps
module sau_cfg_regs
    import sau_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                cfg_we,
    input  logic                                cfg_secure,
    input  logic [1:0]                          cfg_kind,
    input  logic [IDX_W-1:0]                    cfg_region,
    input  logic [SAU_TAG_W-1:0]                cfg_wdata,
    output logic                                unit_en,
    output region_cfg_t [NUM_REGIONS-1:0]       regions
);

    logic                          unit_en_q;
    region_cfg_t [NUM_REGIONS-1:0] regs_q;
    logic                          wr_ok;
    cfg_kind_e                     kind;

    assign wr_ok = cfg_we && cfg_secure;
    assign kind  = cfg_kind_e'(cfg_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            unit_en_q <= 1'b0;
            regs_q    <= '0;
        end else if (wr_ok) begin
            unique case (kind)
                CFG_CTRL:  unit_en_q <= cfg_wdata[0];
                CFG_BASE:  regs_q[cfg_region].base  <= cfg_wdata;
                CFG_LIMIT: regs_q[cfg_region].limit <= cfg_wdata;
                CFG_FLAGS: begin
                    regs_q[cfg_region].en  <= cfg_wdata[0];
                    regs_q[cfg_region].nsc <= cfg_wdata[1];
                end
                default: ;
            endcase
        end
    end

    assign unit_en = unit_en_q;
    assign regions = regs_q;

    // R8: a write from the non-secure world leaves all configuration intact
    p_ns_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_secure) |=> ($stable(unit_en_q) && $stable(regs_q)));

    // R9: a secure enable write is visible right after its edge
    p_enable_write_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_secure && cfg_kind == 2'd0) |=> (unit_en == $past(cfg_wdata[0])));

    // R2: configuration is cleared by reset
    p_reset_clear_r2: assert property (@(posedge clk)
        $past(rst) |-> (!unit_en && regions == '0));

endmodule

// File: rtl/sau_region_match.sv
`timescale 1ns/1ps
module sau_region_match
    import sau_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          unit_en,
    input  region_cfg_t [NUM_REGIONS-1:0] regions,
    input  logic [SAU_ADDR_W-1:0]         addr,
    output logic                          hit_one,
    output logic                          hit_multi,
    output logic [IDX_W-1:0]              hit_idx,
    output logic                          hit_nsc
);

    logic [NUM_REGIONS-1:0] hit_vec;
    logic [CNT_W-1:0]       hit_cnt;
    logic [IDX_W-1:0]       last_idx;
    logic                   last_nsc;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        logic [SAU_ADDR_W-1:0] lo_addr;
        logic [SAU_ADDR_W-1:0] hi_addr;
        assign lo_addr    = {regions[g].base,  {SAU_GRAN_LOG2{1'b0}}};
        assign hi_addr    = {regions[g].limit, {SAU_GRAN_LOG2{1'b1}}};
        assign hit_vec[g] = unit_en && regions[g].en &&
                            (addr >= lo_addr) && (addr <= hi_addr);
    end

    always_comb begin
        hit_cnt  = '0;
        last_idx = '0;
        last_nsc = 1'b0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit_vec[i]) begin
                hit_cnt  = hit_cnt + CNT_W'(1);
                last_idx = IDX_W'(i);
                last_nsc = regions[i].nsc;
            end
        end
    end

    assign hit_one   = (hit_cnt == CNT_W'(1));
    assign hit_multi = (hit_cnt > CNT_W'(1));
    assign hit_idx   = hit_one ? last_idx : '0;
    assign hit_nsc   = hit_one && last_nsc;

    // R5: overlap never reports a single region
    p_multi_no_single_r5: assert property (@(posedge clk) disable iff (rst)
        hit_multi |-> (!hit_one && hit_idx == '0));

    // R10: a disabled unit reports no region at all
    p_disabled_nohit_r10: assert property (@(posedge clk) disable iff (rst)
        !unit_en |-> (!hit_one && !hit_multi));

    // R3: a reported region really holds the address
    p_hit_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        hit_one |-> (regions[hit_idx].en &&
                     addr[SAU_ADDR_W-1:SAU_GRAN_LOG2] >= regions[hit_idx].base &&
                     addr[SAU_ADDR_W-1:SAU_GRAN_LOG2] <= regions[hit_idx].limit));

endmodule

// File: rtl/sau_alias_attr.sv
`timescale 1ns/1ps
module sau_alias_attr
    import sau_pkg::*;
(
    input  logic  alias_sel,
    output attr_t fixed_attr
);

    assign fixed_attr = alias_sel ? ATTR_SEC : ATTR_NSEC;

endmodule

// File: rtl/sau_attr_merge.sv
`timescale 1ns/1ps
module sau_attr_merge
    import sau_pkg::*;
(
    input  logic  hit_one,
    input  logic  hit_nsc,
    input  attr_t fixed_attr,
    output attr_t prog_attr,
    output attr_t final_attr
);

    always_comb begin
        if (!hit_one)     prog_attr = ATTR_SEC;
        else if (hit_nsc) prog_attr = ATTR_NSC;
        else              prog_attr = ATTR_NSEC;
    end

    assign final_attr = attr_stronger(prog_attr, fixed_attr);

endmodule

// File: rtl/sau_attr_unit.sv
`timescale 1ns/1ps
module sau_attr_unit
    import sau_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ALIAS_BIT   = 28,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic                   cfg_secure,
    input  logic [1:0]             cfg_kind,
    input  logic [IDX_W-1:0]       cfg_region,
    input  logic [SAU_TAG_W-1:0]   cfg_wdata,
    input  logic [SAU_ADDR_W-1:0]  lookup_addr,
    output logic                   attr_ns,
    output logic                   attr_nsc,
    output logic                   region_hit,
    output logic [IDX_W-1:0]       region_num,
    output logic                   multi_hit
);

    logic                          unit_en;
    region_cfg_t [NUM_REGIONS-1:0] regions;
    logic                          hit_one;
    logic                          hit_multi;
    logic [IDX_W-1:0]              hit_idx;
    logic                          hit_nsc;
    attr_t                         fixed_attr;
    attr_t                         prog_attr;
    attr_t                         final_attr;

    sau_cfg_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_secure (cfg_secure),
        .cfg_kind   (cfg_kind),
        .cfg_region (cfg_region),
        .cfg_wdata  (cfg_wdata),
        .unit_en    (unit_en),
        .regions    (regions)
    );

    sau_region_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
        .clk       (clk),
        .rst       (rst),
        .unit_en   (unit_en),
        .regions   (regions),
        .addr      (lookup_addr),
        .hit_one   (hit_one),
        .hit_multi (hit_multi),
        .hit_idx   (hit_idx),
        .hit_nsc   (hit_nsc)
    );

    sau_alias_attr u_alias (
        .alias_sel  (lookup_addr[ALIAS_BIT]),
        .fixed_attr (fixed_attr)
    );

    sau_attr_merge u_merge (
        .hit_one    (hit_one),
        .hit_nsc    (hit_nsc),
        .fixed_attr (fixed_attr),
        .prog_attr  (prog_attr),
        .final_attr (final_attr)
    );

    assign attr_ns    = final_attr.ns;
    assign attr_nsc   = final_attr.nsc;
    assign region_hit = hit_one;
    assign region_num = hit_idx;
    assign multi_hit  = hit_multi;

    // R1: the two flags never describe a fourth state
    p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
        !(attr_ns && attr_nsc));

    // R6: the secure alias always resolves to secure
    p_alias_secure_r6: assert property (@(posedge clk) disable iff (rst)
        lookup_addr[ALIAS_BIT] |-> (!attr_ns && !attr_nsc));

    // R2: a disabled unit leaves everything secure
    p_disabled_secure_r2: assert property (@(posedge clk) disable iff (rst)
        !unit_en |-> (!attr_ns && !attr_nsc));

    // R7: the merged result is never weaker than either source
    p_merge_not_weaker_r7: assert property (@(posedge clk) disable iff (rst)
        (attr_rank(final_attr) >= attr_rank(fixed_attr)) &&
        (attr_rank(final_attr) >= attr_rank(prog_attr)));

    // R5: an overlap yields secure
    p_multi_secure_r5: assert property (@(posedge clk) disable iff (rst)
        multi_hit |-> (!attr_ns && !attr_nsc));

endmodule

// File: tb/sau_attr_unit_test.sv
`timescale 1ns/1ps
module sau_attr_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic        cfg_secure;
    logic [1:0]  cfg_kind;
    logic [2:0]  cfg_region;
    logic [26:0] cfg_wdata;
    logic [31:0] lookup_addr;
    logic        attr_ns;
    logic        attr_nsc;
    logic        region_hit;
    logic [2:0]  region_num;
    logic        multi_hit;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sau_attr_unit uut (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_secure  (cfg_secure),
        .cfg_kind    (cfg_kind),
        .cfg_region  (cfg_region),
        .cfg_wdata   (cfg_wdata),
        .lookup_addr (lookup_addr),
        .attr_ns     (attr_ns),
        .attr_nsc    (attr_nsc),
        .region_hit  (region_hit),
        .region_num  (region_num),
        .multi_hit   (multi_hit)
    );

    // expected word: {ns, nsc, hit, num[2:0], multi}
    localparam int NV = 12;
    localparam logic [31:0] V_ADDR [NV] = '{
        32'h0000_1000, 32'h0000_1FFF, 32'h0000_2000, 32'h0000_20E0,
        32'h0000_2100, 32'h0000_0FFC, 32'h1000_0010, 32'h1000_1000,
        32'h0000_3040, 32'h0000_3090, 32'h0000_3100, 32'h0000_4010
    };
    localparam logic [6:0] V_EXP [NV] = '{
        7'b1010000, 7'b1010000, 7'b0110010, 7'b0110010,
        7'b0000000, 7'b0000000, 7'b0010100, 7'b0011100,
        7'b1010110, 7'b0000001, 7'b1011000, 7'b0000000
    };
    localparam string V_REQ [NV] = '{
        "R3", "R3", "R3", "R3", "R4", "R4", "R7", "R7", "R3", "R5", "R3", "R10"
    };

    task automatic check(input string req, input logic [31:0] a, input logic [6:0] exp);
        logic [6:0] got;
        got = {attr_ns, attr_nsc, region_hit, region_num, multi_hit};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%b expected=%b", req, a, got, exp);
        end
    endtask

    task automatic look(input string req, input logic [31:0] a, input logic [6:0] exp);
        @(negedge clk);
        lookup_addr = a;
        #1;
        check(req, a, exp);
    endtask

    task automatic wr(input logic sec, input logic [1:0] kind, input logic [2:0] idx,
                      input logic [26:0] data);
        @(negedge clk);
        cfg_we     = 1'b1;
        cfg_secure = sec;
        cfg_kind   = kind;
        cfg_region = idx;
        cfg_wdata  = data;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic region(input logic [2:0] idx, input logic [31:0] lo, input logic [31:0] hi,
                          input logic [1:0] flags);
        wr(1'b1, 2'd1, idx, lo[31:5]);
        wr(1'b1, 2'd2, idx, hi[31:5]);
        wr(1'b1, 2'd3, idx, {25'd0, flags});
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_secure = 1'b0; cfg_kind = '0;
        cfg_region = '0; cfg_wdata = '0; lookup_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2: reset state, fixed non-secure alias still secure while disabled
        look("R2", 32'h0000_1000, 7'b0000000);
        look("R2", 32'h0FFF_FFE0, 7'b0000000);

        region(3'd0, 32'h0000_1000, 32'h0000_1FE0, 2'b01);
        region(3'd1, 32'h0000_2000, 32'h0000_20E0, 2'b11);
        region(3'd2, 32'h1000_0000, 32'h1000_0FE0, 2'b01);
        region(3'd3, 32'h0000_3000, 32'h0000_30E0, 2'b01);
        region(3'd4, 32'h0000_3080, 32'h0000_31E0, 2'b01);
        region(3'd5, 32'h0000_4000, 32'h0000_4FE0, 2'b00);
        region(3'd6, 32'h1000_1000, 32'h1000_10E0, 2'b11);

        // R10: regions programmed but unit still off
        look("R10", 32'h0000_1000, 7'b0000000);
        wr(1'b1, 2'd0, 3'd0, 27'd1);

        for (int i = 0; i < NV; i++) look(V_REQ[i], V_ADDR[i], V_EXP[i]);

        // R1: callable encoding is ns=0 nsc=1
        look("R1", 32'h0000_2040, 7'b0110010);
        // R6: same offset, secure alias forced secure
        look("R6", 32'h1000_1FFF, 7'b0000000);

        // R8: non-secure writes ignored
        wr(1'b0, 2'd0, 3'd0, 27'd0);
        look("R8", 32'h0000_1000, 7'b1010000);
        wr(1'b0, 2'd1, 3'd0, 27'h400_0000);
        look("R8", 32'h0000_1000, 7'b1010000);
        wr(1'b0, 2'd3, 3'd5, 27'd1);
        look("R8", 32'h0000_4010, 7'b0000000);

        // R9: region 0 becomes callable only after the capturing edge
        @(negedge clk);
        lookup_addr = 32'h0000_1000;
        cfg_we = 1'b1; cfg_secure = 1'b1; cfg_kind = 2'd3;
        cfg_region = 3'd0; cfg_wdata = 27'd3;
        #1 check("R9", lookup_addr, 7'b1010000);
        @(posedge clk);
        #1 cfg_we = 1'b0;
        check("R9", lookup_addr, 7'b0110000);

        // R10: clearing region enable, then unit enable
        wr(1'b1, 2'd3, 3'd3, 27'd0);
        look("R10", 32'h0000_3090, 7'b1011000);
        wr(1'b1, 2'd0, 3'd0, 27'd0);
        look("R10", 32'h0000_1000, 7'b0000000);
        look("R10", 32'h0000_2000, 7'b0000000);

        // R2: reset after programming clears everything
        wr(1'b1, 2'd0, 3'd0, 27'd1);
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        look("R2", 32'h0000_2000, 7'b0000000);
        wr(1'b1, 2'd0, 3'd0, 27'd1);
        look("R2", 32'h0000_2000, 7'b0000000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule